// File: doc/BRIEF.md
# Local-Maximum Corner Picker over a 7×7 Window

This block takes a raster-order stream of per-pixel corner strengths and per-pixel pass/fail flags from an upstream corner detector. It keeps six previous image lines in line buffers, each as deep as the programmed line width, and assembles a 7×7 register window around a centre pixel. A pixel is kept as a feature only when two conditions hold. Its own flag must be set. Its strength must also beat every other pixel in the window, and all 48 comparisons are made side by side in one step.

Column and row counters follow the stream. Their values pass through a short delay line so that every feature leaves with the exact coordinates of the centre being judged. A one-cycle write strobe comes with each coordinate pair, ready to feed a downstream coordinate buffer.

The window moves only on accepted input beats, so idle cycles in the stream do no harm. A start-of-frame pulse on the first beat sets the raster position back to the origin.

Top module: `nms7_peak`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_we` is low and `out_x`/`out_y` read zero.
- R2: For a centre pixel (x, y) in the valid region, a feature is reported if and only if its flag is set and its strength wins against all 48 other pixels of the 7×7 window centred on it.
- R3: Ties are broken in raster order. The centre must be strictly greater than neighbours that arrive before it (rows above, or the same row further left) and greater than or equal to neighbours that arrive after it. A flat plateau therefore yields only its first pixel in raster order.
- R4: A centre whose flag is clear is never reported, whatever its strength.
- R5: No feature is reported for a centre with x < 3, x > width−4 or y < 3. Rows near the bottom are never judged, because their windows are never completed.
- R6: `out_x` and `out_y` give the column and row of the reported centre, counted from zero from the start-of-frame beat.
- R7: The column counter wraps from width−1 to 0 and the row counter then advances. A beat with `sof` high is taken as column 0, row 0, even in the middle of a line.
- R8: Cycles with `in_valid` low shift nothing. The same frame delivered with arbitrary idle gaps yields the same list of features.
- R9: The strobe for centre (x, y) rises in the cycle that follows the clock edge after the edge that accepts pixel (x+3, y+3). `out_we` is high only two edges after an accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Marks the beat carrying the first pixel of a frame |
| in_valid | input | 1 | An input pixel is present in this cycle |
| in_score | input | SCORE_W | Corner strength of the pixel |
| in_corner | input | 1 | Segment-test pass flag of the pixel |
| line_width | input | $clog2(MAX_W)+1 | Pixels per image line (7..MAX_W), held stable during a frame |
| out_we | output | 1 | Write strobe: a feature is being reported |
| out_x | output | $clog2(MAX_W) | Column of the reported feature |
| out_y | output | ROW_W | Row of the reported feature |

## Verification
The bench builds the block with 8-bit strengths, line buffers 16 entries deep and a 10-bit row counter. At that size a whole frame of 9 to 12 pixels per line is small enough to judge every centre in it against a reference computed in the bench. Several random images, an image with a flat plateau, an image with all flags cleared, an image with peaks placed on the border, a frame that restarts in mid-line and a frame sent with random idle gaps are each swept completely. This brings into reach the tie order, the exclusion band at the edges, counter wrap at two widths and the exact cycle of every strobe.

// File: rtl/nms7_peak.sv
module nms7_peak #(
  parameter int SCORE_W = 8,
  parameter int MAX_W   = 64,
  parameter int ROW_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sof,
  input  logic                       in_valid,
  input  logic [SCORE_W-1:0]         in_score,
  input  logic                       in_corner,
  input  logic [$clog2(MAX_W):0]     line_width,
  output logic                       out_we,
  output logic [$clog2(MAX_W)-1:0]   out_x,
  output logic [ROW_W-1:0]           out_y
);
  localparam int COL_W = $clog2(MAX_W);
  localparam int LWW   = COL_W + 1;
  localparam int WIN   = 7;
  localparam int HALF  = WIN / 2;
  localparam int LINES = WIN - 1;
  localparam int CW    = SCORE_W + 1;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] bx;
  logic [ROW_W-1:0] by;
  logic             last_col;

  assign bx       = sof ? '0 : col;
  assign by       = sof ? '0 : row;
  assign last_col = ({1'b0, bx} == line_width - LWW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (in_valid) begin
      col <= last_col ? '0 : bx + COL_W'(1);
      row <= last_col ? by + ROW_W'(1) : by;
    end

  logic [CW-1:0] line_mem [LINES][MAX_W];
  logic [CW-1:0] col_vec  [WIN];

  always_comb begin
    col_vec[0] = {in_corner, in_score};
    for (int i = 1; i < WIN; i++) col_vec[i] = line_mem[i-1][bx];
  end

  always_ff @(posedge clk)
    if (in_valid)
      for (int i = 0; i < LINES; i++) line_mem[i][bx] <= col_vec[i];

  logic [CW-1:0] win [WIN][WIN];

  always_ff @(posedge clk)
    if (in_valid)
      for (int r = 0; r < WIN; r++) begin
        win[r][0] <= col_vec[r];
        for (int k = 1; k < WIN; k++) win[r][k] <= win[r][k-1];
      end

  logic [COL_W-1:0] dx [HALF+1];
  logic [ROW_W-1:0] dy [HALF+1];
  logic             fresh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int d = 0; d <= HALF; d++) begin
        dx[d] <= '0;
        dy[d] <= '0;
      end
      fresh <= 1'b0;
    end else begin
      fresh <= in_valid;
      if (in_valid) begin
        dx[0] <= bx;
        dy[0] <= by;
        for (int d = 1; d <= HALF; d++) begin
          dx[d] <= dx[d-1];
          dy[d] <= dy[d-1];
        end
      end
    end

  logic [SCORE_W-1:0] centre;
  logic               is_max;
  logic               border_ok;

  assign centre = win[HALF][HALF][SCORE_W-1:0];

  always_comb begin
    is_max = 1'b1;
    for (int r = 0; r < WIN; r++)
      for (int k = 0; k < WIN; k++)
        if (r != HALF || k != HALF) begin
          if (r > HALF || (r == HALF && k > HALF))
            is_max = is_max & (centre >  win[r][k][SCORE_W-1:0]);
          else
            is_max = is_max & (centre >= win[r][k][SCORE_W-1:0]);
        end
  end

  assign border_ok = (dy[HALF] >= ROW_W'(2*HALF)) && (dx[HALF] >= COL_W'(HALF)) &&
                     (({1'b0, dx[HALF]} + LWW'(HALF)) < line_width);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_we <= 1'b0;
      out_x  <= '0;
      out_y  <= '0;
    end else begin
      out_we <= fresh && is_max && win[HALF][HALF][SCORE_W] && border_ok;
      if (fresh && is_max && win[HALF][HALF][SCORE_W] && border_ok) begin
        out_x <= dx[HALF];
        out_y <= dy[HALF] - ROW_W'(HALF);
      end
    end
endmodule

// File: rtl/nms7_peak_chk.sv
module nms7_peak_chk #(
  parameter int MAX_W = 64,
  parameter int ROW_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [$clog2(MAX_W):0]   line_width,
  input logic                     out_we,
  input logic [$clog2(MAX_W)-1:0] out_x,
  input logic [ROW_W-1:0]         out_y
);
  localparam int COL_W = $clog2(MAX_W);

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !out_we);

  assert_strobe_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> $past(in_valid, 2));

  assert_left_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_x >= COL_W'(3));

  assert_right_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> ({1'b0, out_x} + (COL_W+1)'(3)) < line_width);

  assert_top_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_y >= ROW_W'(3));
endmodule

bind nms7_peak nms7_peak_chk #(.MAX_W(MAX_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_width(line_width),
  .out_we(out_we), .out_x(out_x), .out_y(out_y)
);

// File: tb/sim_nms7_peak.sv
`timescale 1ns/1ps
module sim_nms7_peak;
  localparam int SW  = 8;
  localparam int MW  = 16;
  localparam int RW  = 10;
  localparam int CWW = $clog2(MW);
  localparam int LWW = CWW + 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sof = 1'b0;
  logic           in_valid = 1'b0;
  logic [SW-1:0]  in_score = '0;
  logic           in_corner = 1'b0;
  logic [LWW-1:0] line_width = LWW'(12);
  logic           out_we;
  logic [CWW-1:0] out_x;
  logic [RW-1:0]  out_y;

  nms7_peak #(.SCORE_W(SW), .MAX_W(MW), .ROW_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .in_score(in_score),
    .in_corner(in_corner), .line_width(line_width), .out_we(out_we), .out_x(out_x), .out_y(out_y)
  );

  always #2 clk = ~clk;

  int img [16][16];
  bit flg [16][16];
  int W = 12, H = 10;
  int beat_cyc [256];
  int cyc = 0;
  int obs_n = 0;
  int obs_x [256];
  int obs_y [256];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && out_we) begin
      int idx;
      idx = (int'(out_y) + 3) * W + int'(out_x) + 3;
      if (obs_n < 256) begin
        obs_x[obs_n] = int'(out_x);
        obs_y[obs_n] = int'(out_y);
      end
      obs_n++;
      chk(int'(out_x) >= 3 && int'(out_x) <= W - 4 && int'(out_y) >= 3, "R5 border", int'(out_x), 3);
      if (idx >= 0 && idx < 256) chk(cyc == beat_cyc[idx] + 1, "R9 latency", cyc, beat_cyc[idx] + 1);
    end

  function automatic bit peak(int xc, int yc);
    if (!flg[yc][xc]) return 1'b0;
    for (int dy = -3; dy <= 3; dy++)
      for (int dx = -3; dx <= 3; dx++)
        if (dy != 0 || dx != 0) begin
          if (dy < 0 || (dy == 0 && dx < 0)) begin
            if (!(img[yc][xc] > img[yc+dy][xc+dx])) return 1'b0;
          end else if (!(img[yc][xc] >= img[yc+dy][xc+dx])) return 1'b0;
        end
    return 1'b1;
  endfunction

  task automatic fill(int maxv, int fmode);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        img[y][x] = $urandom_range(0, maxv);
        flg[y][x] = (fmode == 1) ? 1'b1 : (fmode == 2) ? 1'b0 : ($urandom_range(0, 9) < 7);
      end
  endtask

  task automatic beat(int x, int y, bit s, bit gaps);
    if (gaps) repeat ($urandom_range(0, 2)) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid  = 1'b1;
    sof       = s;
    in_score  = SW'(img[y][x]);
    in_corner = flg[y][x];
    beat_cyc[y * W + x] = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0;
    sof      = 1'b0;
  endtask

  task automatic run_frame(bit gaps, string tag);
    int ex;
    obs_n = 0;
    line_width = LWW'(W);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) beat(x, y, (x == 0 && y == 0), gaps);
    repeat (6) @(negedge clk);
    ex = 0;
    for (int yc = 3; yc <= H - 4; yc++)
      for (int xc = 3; xc <= W - 4; xc++)
        if (peak(xc, yc)) begin
          if (ex < obs_n && ex < 256) begin
            chk(obs_x[ex] == xc, {tag, " R2 R6 column"}, obs_x[ex], xc);
            chk(obs_y[ex] == yc, {tag, " R2 R6 row"}, obs_y[ex], yc);
          end
          ex++;
        end
    chk(obs_n == ex, {tag, " R2 feature count"}, obs_n, ex);
  endtask

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk);
    chk(out_we == 1'b0, "R1 strobe in reset", int'(out_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_we == 1'b0, "R1 strobe after reset", int'(out_we), 0);
    chk(out_x == '0 && out_y == '0, "R1 coords after reset", int'(out_x) + int'(out_y), 0);

    W = 12; H = 10;
    for (int n = 0; n < 4; n++) begin
      fill(255, 0);
      run_frame(1'b0, "random R2");
    end

    fill(255, 0);
    run_frame(1'b1, "gaps R8");
    run_frame(1'b0, "gapless twin R8");

    fill(0, 1);
    for (int y = 0; y < 16; y++) for (int x = 0; x < 16; x++) img[y][x] = 10;
    img[4][5] = 200; img[4][6] = 200; img[5][5] = 200; img[5][6] = 200;
    run_frame(1'b0, "plateau R3");
    chk(obs_n == 1, "R3 plateau single", obs_n, 1);
    chk(obs_x[0] == 5 && obs_y[0] == 4, "R3 plateau first pixel", obs_x[0] * 100 + obs_y[0], 504);

    fill(255, 2);
    run_frame(1'b0, "no flags R4");
    chk(obs_n == 0, "R4 no flag no feature", obs_n, 0);

    fill(100, 1);
    img[5][1] = 255; img[5][W-2] = 255; img[1][6] = 255; img[2][2] = 255; img[6][6] = 255;
    run_frame(1'b0, "border R5");
    chk(obs_n >= 1, "R5 interior peak kept", obs_n, 1);

    W = 9; H = 9;
    fill(255, 0);
    line_width = LWW'(W);
    beat(0, 0, 1'b1, 1'b0);
    for (int x = 1; x < 5; x++) beat(x, 0, 1'b0, 1'b0);
    run_frame(1'b0, "restart wrap R7");
    fill(255, 0);
    run_frame(1'b1, "narrow gaps R7 R8");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule